// File: doc/BRIEF.md
# Bit-Position Sign and Zero Extension Unit

This execution unit takes a 64-bit source operand and extends it from a chosen bit. The position input gives the index of the highest bit that is kept. It is not a count of bits, so a byte is extended from index 7, a halfword from 15 and a word from 31. In sign mode the index is first folded into the current operand width, and every bit above it copies the bit found at that index. In zero mode every bit above the index is cleared.

The extended value is merged into the old destination according to the operation size. A sign extension can also update four condition flags from the sampled sign bit: carry, zero, external carry and external zero. A per-bit enable mask chooses which of those four flags change. The unit is combinational from its inputs to a single register stage. It has a synchronous active-high reset, and both results appear one clock after their operands.

Top module: `ext_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `dst_o` and `flags_o` are cleared to zero. Otherwise, each result reflects the inputs sampled at the previous rising edge.
- R2: With `op_sext_i`=1 (sign mode), the effective index is `pos_i` ANDed with (operation bits − 1). Result bits at and below the effective index equal the source. Every bit above it equals the source bit at the effective index, before the merge.
- R3: With `op_sext_i`=0 (zero mode), `pos_i` is used without folding. Source bits [pos:0] are kept and all higher bits are zero, before the merge.
- R4: A size of 1 or 2 bytes replaces only the low 8 or 16 bits of `dst_o`. The remaining bits come from `dst_old_i`.
- R5: A size of 4 bytes writes the low 32 bits and makes bits 63:32 zero.
- R6: A size of 8 bytes writes all 64 bits. Any size code other than 1, 2, 4 or 8 behaves as 8, and this includes the folding width in R2.
- R7: In sign mode with `flag_upd_i`=1 and a sign bit of 0, each flag at bit 0 (carry), 1 (zero), 2 (external carry) or 3 (external zero) whose `flag_en_i` bit is set is cleared.
- R8: In sign mode with `flag_upd_i`=1 and a sign bit of 1, those same enabled flags among bits 0 to 3 are set.
- R9: Flag bits 4 and above, flags whose enable bit is clear, and all flags when `flag_upd_i`=0 pass from `flags_i` to `flags_o` unchanged.
- R10: In zero mode `flags_o` equals `flags_i`, whatever the values of `flag_upd_i` and `flag_en_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Source value to extend |
| dst_old_i | input | 64 | Previous destination value used by the merge |
| pos_i | input | 6 | Index of the highest kept bit |
| size_i | input | 4 | Operation size in bytes (1, 2, 4, 8) |
| op_sext_i | input | 1 | 1 = sign extension, 0 = zero extension |
| flag_upd_i | input | 1 | Flag update requested |
| flag_en_i | input | 8 | Per-flag enable mask |
| flags_i | input | 8 | Incoming condition flags |
| dst_o | output | 64 | Registered merged result |
| flags_o | output | 8 | Registered updated flags |

## Verification
The bound assertions check several properties on every cycle:
- Both outputs are cleared after reset.
- The upper bits follow the old destination when the size is one byte.
- The upper half is zero when the size is four bytes.
- Flags outside the four extension flags never change.
- Zero mode never alters the flags.
- Zero mode at the full size leaves nothing set above the index.

Some behaviour depends on the sampled sign bit, so only the bench's sweep can show it:
- the sign-bit value and its copy into the upper bits;
- the wrap of an out-of-range index at each size;
- setting or clearing of the enabled flags.

The sweep covers every index, every size code including an illegal one, both modes and several source patterns. Each result is compared against a shift-and-mask model.

// File: rtl/ext_pkg.sv
package ext_pkg;
  // Condition-flag bit positions touched by sign extension
  localparam int FL_CARRY  = 0;
  localparam int FL_ZERO   = 1;
  localparam int FL_XCARRY = 2;
  localparam int FL_XZERO  = 3;

  typedef enum logic {
    EXT_ZERO = 1'b0,
    EXT_SIGN = 1'b1
  } ext_op_e;

  function automatic bit is_ext_flag(int idx);
    return (idx == FL_CARRY) || (idx == FL_ZERO) ||
           (idx == FL_XCARRY) || (idx == FL_XZERO);
  endfunction
endpackage

// File: rtl/ext_core.sv
module ext_core #(
  parameter int XLEN = 64,
  parameter int PW   = $clog2(XLEN),
  parameter int SW   = $clog2(XLEN / 8) + 1
) (
  input  logic [XLEN-1:0] src_i,
  input  logic [PW-1:0]   pos_i,
  input  logic [SW-1:0]   size_i,
  input  ext_pkg::ext_op_e op_i,
  output logic [XLEN-1:0] ext_o,
  output logic            sign_o,
  output logic            size_ok_o
);
  localparam int MAXB = XLEN / 8;

  logic [SW+2:0]   size_bits;
  logic [PW-1:0]   bits_m1;
  logic [PW-1:0]   eff_pos;
  logic [XLEN-1:0] keep;

  assign size_ok_o = (size_i != '0) &&
                     ((size_i & (size_i - 1'b1)) == '0) &&
                     (size_i <= SW'(MAXB));
  assign size_bits = {size_i, 3'b000};
  assign bits_m1   = size_ok_o ? PW'(size_bits - 1'b1) : PW'(XLEN - 1);
  assign eff_pos   = (op_i == ext_pkg::EXT_SIGN) ? (pos_i & bits_m1) : pos_i;
  assign sign_o    = src_i[eff_pos];

  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    assign keep[i]  = (eff_pos >= PW'(i));
    assign ext_o[i] = keep[i] ? src_i[i]
                              : ((op_i == ext_pkg::EXT_SIGN) & sign_o);
  end
endmodule

// File: rtl/ext_merge.sv
module ext_merge #(
  parameter int XLEN     = 64,
  parameter int SW       = $clog2(XLEN / 8) + 1,
  parameter int ZU_BYTES = 4
) (
  input  logic [XLEN-1:0] ext_i,
  input  logic [XLEN-1:0] old_i,
  input  logic [SW-1:0]   size_i,
  input  logic            size_ok_i,
  output logic [XLEN-1:0] res_o
);
  localparam int NB = XLEN / 8;

  logic zero_upper;
  assign zero_upper = size_ok_i && (size_i == SW'(ZU_BYTES));

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic lane_wr;
    assign lane_wr = !size_ok_i || (SW'(b) < size_i);
    assign res_o[b*8 +: 8] = lane_wr    ? ext_i[b*8 +: 8] :
                             zero_upper ? 8'h00 : old_i[b*8 +: 8];
  end
endmodule

// File: rtl/ext_flags.sv
module ext_flags #(
  parameter int FW = 8
) (
  input  logic [FW-1:0] flags_i,
  input  logic [FW-1:0] en_i,
  input  logic          upd_i,
  input  ext_pkg::ext_op_e op_i,
  input  logic          sign_i,
  output logic [FW-1:0] flags_o
);
  logic act;
  assign act = upd_i && (op_i == ext_pkg::EXT_SIGN);

  for (genvar f = 0; f < FW; f++) begin : g_flag
    if (ext_pkg::is_ext_flag(f)) begin : g_grp
      assign flags_o[f] = (act && en_i[f]) ? sign_i : flags_i[f];
    end else begin : g_pass
      assign flags_o[f] = flags_i[f];
    end
  end
endmodule

// File: rtl/ext_unit.sv
module ext_unit #(
  parameter int XLEN     = 64,
  parameter int FW       = 8,
  parameter int ZU_BYTES = 4,
  parameter int PW       = $clog2(XLEN),
  parameter int SW       = $clog2(XLEN / 8) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] dst_old_i,
  input  logic [PW-1:0]   pos_i,
  input  logic [SW-1:0]   size_i,
  input  logic            op_sext_i,
  input  logic            flag_upd_i,
  input  logic [FW-1:0]   flag_en_i,
  input  logic [FW-1:0]   flags_i,
  output logic [XLEN-1:0] dst_o,
  output logic [FW-1:0]   flags_o
);
  ext_pkg::ext_op_e op;
  logic [XLEN-1:0]  ext_val;
  logic [XLEN-1:0]  merged;
  logic [FW-1:0]    fl_nxt;
  logic             sign_bit;
  logic             size_ok;

  assign op = op_sext_i ? ext_pkg::EXT_SIGN : ext_pkg::EXT_ZERO;

  ext_core #(.XLEN(XLEN), .PW(PW), .SW(SW)) u_core (
    .src_i(src_i), .pos_i(pos_i), .size_i(size_i), .op_i(op),
    .ext_o(ext_val), .sign_o(sign_bit), .size_ok_o(size_ok)
  );

  ext_merge #(.XLEN(XLEN), .SW(SW), .ZU_BYTES(ZU_BYTES)) u_merge (
    .ext_i(ext_val), .old_i(dst_old_i), .size_i(size_i),
    .size_ok_i(size_ok), .res_o(merged)
  );

  ext_flags #(.FW(FW)) u_flags (
    .flags_i(flags_i), .en_i(flag_en_i), .upd_i(flag_upd_i),
    .op_i(op), .sign_i(sign_bit), .flags_o(fl_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_o   <= '0;
      flags_o <= '0;
    end else begin
      dst_o   <= merged;
      flags_o <= fl_nxt;
    end
  end
endmodule

// File: rtl/ext_unit_chk.sv
module ext_unit_chk #(
  parameter int XLEN = 64,
  parameter int FW   = 8,
  parameter int PW   = $clog2(XLEN),
  parameter int SW   = $clog2(XLEN / 8) + 1
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] dst_old_i,
  input logic [PW-1:0]   pos_i,
  input logic [SW-1:0]   size_i,
  input logic            op_sext_i,
  input logic [FW-1:0]   flags_i,
  input logic [XLEN-1:0] dst_o,
  input logic [FW-1:0]   flags_o
);
  localparam logic [FW-1:0] GRP = FW'((1 << ext_pkg::FL_CARRY) | (1 << ext_pkg::FL_ZERO) |
                                      (1 << ext_pkg::FL_XCARRY) | (1 << ext_pkg::FL_XZERO));
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dst_o == '0) && (flags_o == '0));

  a_r4_byte_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(size_i) == SW'(1)) |-> dst_o[XLEN-1:8] == $past(dst_old_i[XLEN-1:8]));

  a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(size_i) == SW'(4)) |-> dst_o[XLEN-1:32] == '0);

  a_r3_zext_top_clear: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(op_sext_i) && $past(size_i) == SW'(XLEN / 8))
      |-> ((dst_o >> $past(pos_i)) >> 1) == '0);

  a_r9_outside_flags: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((flags_o ^ $past(flags_i)) & ~GRP) == '0);

  a_r10_zext_flags: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(op_sext_i)) |-> flags_o == $past(flags_i));
endmodule

bind ext_unit ext_unit_chk #(.XLEN(XLEN), .FW(FW), .PW(PW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .dst_old_i(dst_old_i), .pos_i(pos_i), .size_i(size_i),
  .op_sext_i(op_sext_i), .flags_i(flags_i), .dst_o(dst_o), .flags_o(flags_o)
);

// File: tb/ext_unit_tb.sv
`timescale 1ns/1ps
module ext_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_i = '0, dst_old_i = '0;
  logic [5:0]  pos_i = '0;
  logic [3:0]  size_i = 4'd8;
  logic        op_sext_i = 1'b0, flag_upd_i = 1'b0;
  logic [7:0]  flag_en_i = '0, flags_i = '0;
  logic [63:0] dst_o;
  logic [7:0]  flags_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] lcg = 64'h1234_5678_9abc_def1;

  always #5 clk = ~clk;

  ext_unit u_dut (
    .clk(clk), .rst(rst), .src_i(src_i), .dst_old_i(dst_old_i), .pos_i(pos_i),
    .size_i(size_i), .op_sext_i(op_sext_i), .flag_upd_i(flag_upd_i),
    .flag_en_i(flag_en_i), .flags_i(flags_i), .dst_o(dst_o), .flags_o(flags_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int eff_idx(logic op, logic [3:0] sz, logic [5:0] pos);
    int w;
    w = (sz == 1 || sz == 2 || sz == 4 || sz == 8) ? int'(sz) * 8 : 64;
    return op ? (int'(pos) % w) : int'(pos);
  endfunction

  function automatic logic [63:0] ref_dst(logic op, logic [3:0] sz, logic [5:0] pos,
                                          logic [63:0] src, logic [63:0] old);
    int p;
    logic [63:0] keep, e;
    p = eff_idx(op, sz, pos);
    keep = (p == 63) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (p + 1)) - 64'd1);
    e = (op && src[p]) ? (src | ~keep) : (src & keep);
    case (sz)
      4'd1:    return {old[63:8], e[7:0]};
      4'd2:    return {old[63:16], e[15:0]};
      4'd4:    return {32'h0, e[31:0]};
      default: return e;
    endcase
  endfunction

  function automatic logic [7:0] ref_flags(logic op, logic upd, logic s,
                                           logic [7:0] en, logic [7:0] fl);
    logic [7:0] m;
    m = en & 8'h0F;
    if (op && upd) return s ? (fl | m) : (fl & ~m);
    return fl;
  endfunction

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] sizes [5];
    sizes[0] = 4'd1; sizes[1] = 4'd2; sizes[2] = 4'd4; sizes[3] = 4'd8; sizes[4] = 4'd3;

    // R1: reset clears outputs even with busy inputs
    src_i = 64'hFFFF_FFFF_FFFF_FFFF; dst_old_i = 64'hA5A5_A5A5_A5A5_A5A5;
    flags_i = 8'hFF; flag_en_i = 8'hFF; flag_upd_i = 1'b1; op_sext_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(dst_o == '0, "R1 dst reset", dst_o, 64'h0);
    chk(flags_o == '0, "R1 flags reset", {56'h0, flags_o}, 64'h0);
    rst = 1'b0;

    for (int op = 0; op < 2; op++) begin
      for (int si = 0; si < 5; si++) begin
        for (int pos = 0; pos < 64; pos++) begin
          for (int pat = 0; pat < 4; pat++) begin
            logic [63:0] ed;
            logic [7:0]  ef;
            int          p;
            string       rd, rm, rf;
            lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
            @(negedge clk);
            op_sext_i  = op[0];
            size_i     = sizes[si];
            pos_i      = pos[5:0];
            case (pat)
              0: src_i = 64'h0;
              1: src_i = 64'hFFFF_FFFF_FFFF_FFFF;
              2: src_i = 64'h5555_AAAA_3333_CCCC ^ {58'h0, pos[5:0]};
              default: src_i = lcg;
            endcase
            dst_old_i  = {lcg[31:0], lcg[63:32]};
            flags_i    = lcg[47:40];
            flag_en_i  = lcg[55:48];
            flag_upd_i = (pat != 2);
            ed = ref_dst(op[0], sizes[si], pos[5:0], src_i, dst_old_i);
            p  = eff_idx(op[0], sizes[si], pos[5:0]);
            ef = ref_flags(op[0], flag_upd_i, src_i[p], flag_en_i, flags_i);
            @(negedge clk);
            rd = op ? "R2" : "R3";
            rm = (si < 2) ? "R4" : (si == 2) ? "R5" : "R6";
            chk(dst_o == ed, $sformatf("%s/%s op=%0d size=%0d pos=%0d", rd, rm, op, sizes[si], pos),
                dst_o, ed);
            if (op == 0)            rf = "R10";
            else if (!flag_upd_i)   rf = "R9";
            else if (src_i[p])      rf = "R8";
            else                    rf = "R7";
            chk(flags_o == ef, $sformatf("%s flags size=%0d pos=%0d", rf, sizes[si], pos),
                {56'h0, flags_o}, {56'h0, ef});
          end
        end
      end
    end

    // R9: enable mask zero leaves flags untouched in sign mode
    @(negedge clk);
    op_sext_i = 1'b1; flag_upd_i = 1'b1; flag_en_i = 8'h00; flags_i = 8'h96;
    size_i = 4'd8; pos_i = 6'd7; src_i = 64'h80;
    @(negedge clk);
    chk(flags_o == 8'h96, "R9 zero enable mask", {56'h0, flags_o}, 64'h96);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule